// File: doc/BRIEF.md
# CPU-Side Bidirectional Port with Per-Bit Direction

This block is a small parallel port that sits inside a processor and answers two addresses of the processor's own memory map. One address holds a direction register with one bit per pin. The other holds the port's data latch. Each pin can be an input or an output on its own, so one port can mix inputs and outputs. Software can also drive some pins as a memory-bank selector.

The processor talks to the block over a plain synchronous bus: address, write strobe, write data and combinational read data. On the pad side the block drives an output vector and an output-enable vector. It receives an input vector, which passes through a multi-stage synchroniser before it reaches the read path. While the bus address hits either port register, the block raises an inhibit line so that external memory ignores the access.

Top module: `cpu_pio_port`

## Requirements
- R1: After reset the direction register, the output-enable vector and the output latch are all zero, so every pin is an input.
- R2: A write to address 0x0000 loads the direction register. A direction bit of 1 makes that pin an output and 0 makes it an input. `pad_oe` shows the new value from the next clock edge, and a read of 0x0000 returns it.
- R3: A write to address 0x0001 loads the output latch. `pad_out` shows the new value from the next clock edge, whatever the direction setting.
- R4: A read of 0x0001 returns, for bit i, the latch bit when direction bit i is 1, and the synchronised pad input bit when direction bit i is 0.
- R5: A change on `pad_in` appears in the 0x0001 read data after exactly two rising clock edges, and not after one.
- R6: The latch keeps its written value while a pin is an input. Switching that pin to output then drives the value written last.
- R7: `ext_mem_inhibit` is 1 exactly when `bus_addr` is 0x0000 or 0x0001, combinationally and regardless of `bus_we`.
- R8: Writes to any other address change neither the direction register nor the latch.
- R9: Reads of any address other than 0x0000 and 0x0001 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Processor address |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| ext_mem_inhibit | output | 1 | High when the address belongs to the port |
| pad_out | output | 8 | Output latch towards the pads |
| pad_oe | output | 8 | Per-pin output enable (direction register) |
| pad_in | input | 8 | Raw pad levels |

## Verification
The assertions assume three things about the inputs. `bus_addr`, `bus_we` and `bus_wdata` are steady around each rising edge. Reset is held for at least one edge. `pad_in` may change at any time, but only the synchronised copy is checked against the read data.

The bench changes every input at the falling clock edge, never near the sampling edge. Before it compares a read of address 1, it holds `pad_in` steady for at least three edges. The only exception is the deliberate two-edge latency probe for R5.

// File: rtl/cpu_pio_pkg.sv
package cpu_pio_pkg;
   localparam int unsigned BUS_ADDR_W  = 16;
   localparam int unsigned BUS_DATA_W  = 8;
   localparam int unsigned MIN_SYNC    = 2;

   typedef enum logic [1:0] {
      SEL_NONE = 2'b00,
      SEL_DIR  = 2'b01,
      SEL_DATA = 2'b10
   } pio_sel_e;
endpackage

// File: rtl/cpu_pio_decode.sv
module cpu_pio_decode
   import cpu_pio_pkg::*;
#(
   parameter int unsigned           ADDR_W    = BUS_ADDR_W,
   parameter logic [ADDR_W-1:0]     DIR_ADDR  = '0,
   parameter logic [ADDR_W-1:0]     DATA_ADDR = ADDR_W'(1)
) (
   input  logic [ADDR_W-1:0] addr,
   output pio_sel_e          sel,
   output logic              hit
);
   initial begin
      if (DIR_ADDR == DATA_ADDR)
         $fatal(1, "cpu_pio_decode: register addresses must differ");
   end

   always_comb begin
      if (addr == DIR_ADDR)       sel = SEL_DIR;
      else if (addr == DATA_ADDR) sel = SEL_DATA;
      else                        sel = SEL_NONE;
   end

   assign hit = (sel != SEL_NONE);
endmodule

// File: rtl/cpu_pio_sync.sv
module cpu_pio_sync
   import cpu_pio_pkg::*;
#(
   parameter int unsigned WIDTH  = BUS_DATA_W,
   parameter int unsigned STAGES = MIN_SYNC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   initial begin
      if (STAGES < MIN_SYNC)
         $fatal(1, "cpu_pio_sync: at least two stages required");
      if (WIDTH < 1)
         $fatal(1, "cpu_pio_sync: width must be positive");
   end

   logic [WIDTH-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/cpu_pio_regs.sv
module cpu_pio_regs
   import cpu_pio_pkg::*;
#(
   parameter int unsigned WIDTH = BUS_DATA_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  pio_sel_e         sel,
   input  logic [WIDTH-1:0] wdata,
   input  logic [WIDTH-1:0] pins_sync,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] latch_q,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] port_view;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '0;
         latch_q <= '0;
      end else if (we) begin
         if (sel == SEL_DIR)  dir_q   <= wdata;
         if (sel == SEL_DATA) latch_q <= wdata;
      end
   end

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         assign port_view[b] = dir_q[b] ? latch_q[b] : pins_sync[b];
      end
   endgenerate

   always_comb begin
      case (sel)
         SEL_DIR:  rdata = dir_q;
         SEL_DATA: rdata = port_view;
         default:  rdata = '0;
      endcase
   end

   AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_DIR) |=> dir_q == $past(wdata)); // R2
   AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_DATA) |=> latch_q == $past(wdata)); // R3
   AST_MISS_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && sel != SEL_NONE) |=> ($stable(dir_q) && $stable(latch_q))); // R8
   AST_LATCH_HELD_ON_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_DIR) |=> $stable(latch_q)); // R6
   AST_READ_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE) |-> rdata == '0); // R9
endmodule

// File: rtl/cpu_pio_port.sv
module cpu_pio_port
   import cpu_pio_pkg::*;
#(
   parameter int unsigned ADDR_W      = BUS_ADDR_W,
   parameter int unsigned WIDTH       = BUS_DATA_W,
   parameter int unsigned SYNC_STAGES = MIN_SYNC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   output logic              ext_mem_inhibit,
   output logic [WIDTH-1:0]  pad_out,
   output logic [WIDTH-1:0]  pad_oe,
   input  logic [WIDTH-1:0]  pad_in
);
   initial begin
      if (ADDR_W < 1)
         $fatal(1, "cpu_pio_port: address width must be at least 1");
   end

   pio_sel_e         sel;
   logic             hit;
   logic [WIDTH-1:0] pins_sync;

   cpu_pio_decode #(
      .ADDR_W   (ADDR_W),
      .DIR_ADDR ('0),
      .DATA_ADDR(ADDR_W'(1))
   ) u_dec (
      .addr(bus_addr),
      .sel (sel),
      .hit (hit)
   );

   cpu_pio_sync #(
      .WIDTH (WIDTH),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async(pad_in),
      .q_sync (pins_sync)
   );

   cpu_pio_regs #(
      .WIDTH(WIDTH)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (bus_we),
      .sel      (sel),
      .wdata    (bus_wdata),
      .pins_sync(pins_sync),
      .dir_q    (pad_oe),
      .latch_q  (pad_out),
      .rdata    (bus_rdata)
   );

   assign ext_mem_inhibit = hit;

   AST_INHIBIT_LOW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr > ADDR_W'(1)) |-> !ext_mem_inhibit); // R7
   AST_RESET_INPUTS: assert property (@(posedge clk)
      !rst_n |-> (pad_oe == '0 && pad_out == '0)); // R1
endmodule

// File: tb/sim_cpu_pio_port.sv
module sim_cpu_pio_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = 16'h8000;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_wdata = 8'h00;
   logic [7:0]  bus_rdata;
   logic        ext_mem_inhibit;
   logic [7:0]  pad_out;
   logic [7:0]  pad_oe;
   logic [7:0]  pad_in = 8'h00;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   cpu_pio_port u0 (
      .clk            (clk),
      .rst_n          (rst_n),
      .bus_addr       (bus_addr),
      .bus_we         (bus_we),
      .bus_wdata      (bus_wdata),
      .bus_rdata      (bus_rdata),
      .ext_mem_inhibit(ext_mem_inhibit),
      .pad_out        (pad_out),
      .pad_oe         (pad_oe),
      .pad_in         (pad_in)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = 16'h8000;
   endtask

   task automatic rd(input logic [15:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
      bus_addr = 16'h8000;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] v;
      // R1: reset state
      idle(2);
      check("R1 oe", pad_oe, 0);
      check("R1 out", pad_out, 0);
      @(negedge clk); rst_n = 1'b1;
      idle(1);
      rd(16'h0000, v); check("R1 dir read", v, 0);

      // R2 / R3 / R4: sweep every direction pattern
      for (int d = 0; d < 256; d++) begin
         logic [7:0] lat, pin, exp;
         lat = 8'(d) ^ 8'hA5;
         pin = 8'(d * 37 + 11);
         pad_in = pin;
         wr(16'h0000, 8'(d));
         wr(16'h0001, lat);
         idle(2);
         check("R2 oe", pad_oe, d);
         check("R3 out", pad_out, lat);
         rd(16'h0000, v); check("R2 dir read", v, d);
         exp = (lat & 8'(d)) | (pin & ~8'(d));
         rd(16'h0001, v); check("R4 mixed read", v, exp);
      end

      // R5: synchroniser latency
      wr(16'h0000, 8'h00);
      pad_in = 8'h00; idle(3);
      pad_in = 8'hC3;
      @(negedge clk);
      rd(16'h0001, v); check("R5 one edge", v, 8'h00);
      @(negedge clk);
      rd(16'h0001, v); check("R5 two edges", v, 8'hC3);

      // R6: latch retained while input
      wr(16'h0001, 8'h5A);
      pad_in = 8'hFF; idle(3);
      rd(16'h0001, v); check("R6 input view", v, 8'hFF);
      check("R6 latch kept", pad_out, 8'h5A);
      wr(16'h0000, 8'hFF);
      check("R6 drives last", pad_out, 8'h5A);
      rd(16'h0001, v); check("R6 output view", v, 8'h5A);

      // R7 / R9: address sweep
      for (int a = 0; a < 520; a++) begin
         rd(16'(a), v);
         bus_addr = 16'(a); #1;
         check("R7 inhibit", ext_mem_inhibit, (a < 2) ? 1 : 0);
         bus_we = 1'b1; #1;
         check("R7 inhibit we", ext_mem_inhibit, (a < 2) ? 1 : 0);
         bus_we = 1'b0; bus_addr = 16'h8000;
         if (a >= 2) check("R9 miss read", v, 0);
      end
      bus_addr = 16'hFFFF; #1; check("R7 top addr", ext_mem_inhibit, 0);
      bus_addr = 16'h0100; #1; check("R7 alias", ext_mem_inhibit, 0);
      bus_addr = 16'h8000;

      // R8: writes elsewhere ignored
      wr(16'h0000, 8'h3C);
      wr(16'h0001, 8'h96);
      for (int a = 2; a < 300; a += 7) wr(16'(a), 8'(a));
      wr(16'h0100, 8'h00); wr(16'h0101, 8'hFF); wr(16'hFFFF, 8'h11);
      check("R8 oe kept", pad_oe, 8'h3C);
      check("R8 out kept", pad_out, 8'h96);
      rd(16'h0000, v); check("R8 dir read", v, 8'h3C);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule